// File: doc/BRIEF.md
# Ethernet DMA Control and Status Register Block

This block holds the software-visible control state of an Ethernet DMA controller. Software reaches it through a word-addressed read/write bus. The transmit and receive engines use its outputs: the enable bits, the bus-mode word, the list-base addresses and the current-descriptor pointers. Each engine can also load a new value into its own current-descriptor pointer, for example when it steps to the next descriptor or wraps back to the base. When an engine raises status events, it drives single-cycle set pulses, one per status bit. Software clears those bits by writing ones to them.

A single level interrupt is high whenever any status bit is set and its enable bit is also set. A bus write to the transmit poll address stores nothing. Instead it produces a one-cycle start strobe toward the transmit engine.

The bus has no back-pressure and every request is accepted in the cycle it is presented. A read presented with `bus_en`=1 and `bus_we`=0 returns its data on `bus_rdata` with `bus_rvalid`=1 in the following cycle. In all other cycles `bus_rdata` is zero.

Top module: `dma_csr_block`

## Requirements
- R1: After reset, every register reads as zero. `irq`, `tx_poll`, `rx_enable` and `tx_enable` are low, and both current-descriptor pointers are zero.
- R2: A write to the status register (word address 4) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A pulse on `stat_set[k]` sets status bit k. The bit positions are: transmit done 0, transmit list empty 2, receive done 6, receive list empty 7, abnormal summary 15, normal summary 16. When a set pulse and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R4: `irq` is high exactly when (status AND interrupt-enable) is nonzero. The interrupt-enable register is at word address 6.
- R5: A write to the receive list base (address 2) or transmit list base (address 3) stores the value and also loads it into the matching current pointer (addresses 9 and 8).
  - An engine load replaces that pointer and leaves the base unchanged.
  - If a base write and an engine load occur in the same cycle, the base value wins.
  - Bus writes to the pointer addresses have no effect.
- R6: A write to bus mode (address 0) stores the value with bit 0 forced to 0. The stored value drives `bus_mode`.
- R7: A write to the transmit poll address (address 1) raises `tx_poll` for exactly the following cycle and stores nothing. A read of that address returns zero.
- R8: The version register (address 7) always reads 0x1012, whatever was written to it.
- R9: The control register is at address 5. Control bit 1 drives `rx_enable` and control bit 13 drives `tx_enable`.
- R10: Reads return data with `bus_rvalid` high one cycle after the request. Addresses 10 to 15 read as zero, and `bus_rvalid` stays low when no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| stat_set | input | 32 | Per-bit status set pulses from the engines |
| tx_cur_load | input | 1 | Transmit engine loads its current pointer |
| tx_cur_value | input | 32 | Value for the transmit pointer load |
| rx_cur_load | input | 1 | Receive engine loads its current pointer |
| rx_cur_value | input | 32 | Value for the receive pointer load |
| tx_cur_ptr | output | 32 | Current transmit descriptor pointer |
| rx_cur_ptr | output | 32 | Current receive descriptor pointer |
| tx_base | output | 32 | Transmit list base |
| rx_base | output | 32 | Receive list base |
| bus_mode | output | 32 | Bus-mode word |
| tx_enable | output | 1 | Transmission enabled |
| rx_enable | output | 1 | Reception enabled |
| tx_poll | output | 1 | One-cycle transmit start strobe |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted status bit appears on `irq` in the same cycle once its enable is set, and on a status read one cycle after the request. A wrong pointer value shows immediately on `tx_cur_ptr` or `rx_cur_ptr`, so the bench checks these ports straight after base writes, engine loads and the case where both happen together. A lost or stretched poll strobe is visible on `tx_poll` in the cycle after the write, and the bench samples that cycle and the one after it.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  // Word addresses; the engines and software agree on this map.
  localparam int unsigned ADR_BUSMODE = 0;
  localparam int unsigned ADR_TXPOLL  = 1;
  localparam int unsigned ADR_RXBASE  = 2;
  localparam int unsigned ADR_TXBASE  = 3;
  localparam int unsigned ADR_STATUS  = 4;
  localparam int unsigned ADR_CTRL    = 5;
  localparam int unsigned ADR_IEN     = 6;
  localparam int unsigned ADR_VERSION = 7;
  localparam int unsigned ADR_TXCUR   = 8;
  localparam int unsigned ADR_RXCUR   = 9;

  // Control bit positions
  localparam int unsigned CTRL_RX_EN_BIT = 1;
  localparam int unsigned CTRL_TX_EN_BIT = 13;

  // Status bit positions used by the engines
  localparam int unsigned ST_TX_DONE  = 0;
  localparam int unsigned ST_TX_EMPTY = 2;
  localparam int unsigned ST_RX_DONE  = 6;
  localparam int unsigned ST_RX_EMPTY = 7;
  localparam int unsigned ST_ABN_SUM  = 15;
  localparam int unsigned ST_NRM_SUM  = 16;

  typedef struct packed {
    logic busmode;
    logic txpoll;
    logic rxbase;
    logic txbase;
    logic status;
    logic ctrl;
    logic ien;
  } csr_wsel_t;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  output csr_wsel_t         wsel
);
  logic wr;
  assign wr = bus_en && bus_we;

  always_comb begin
    wsel         = '0;
    wsel.busmode = wr && (bus_addr == ADDR_W'(ADR_BUSMODE));
    wsel.txpoll  = wr && (bus_addr == ADDR_W'(ADR_TXPOLL));
    wsel.rxbase  = wr && (bus_addr == ADDR_W'(ADR_RXBASE));
    wsel.txbase  = wr && (bus_addr == ADDR_W'(ADR_TXBASE));
    wsel.status  = wr && (bus_addr == ADDR_W'(ADR_STATUS));
    wsel.ctrl    = wr && (bus_addr == ADDR_W'(ADR_CTRL));
    wsel.ien     = wr && (bus_addr == ADDR_W'(ADR_IEN));
  end
endmodule

// File: rtl/dma_csr_status.sv
module dma_csr_status #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [DATA_W-1:0] clr_mask,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] ien,
  output logic [DATA_W-1:0] status_q,
  output logic              irq
);
  logic [DATA_W-1:0] clr_eff;
  assign clr_eff = clr_wr ? clr_mask : '0;

  // Set pulses take priority over a software clear in the same cycle.
  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_eff) | set_i;
  end

  assign irq = |(status_q & ien);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

  p_w1c_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && set_i == '0) |=> ((status_q & $past(clr_mask)) == '0));

  p_w1c_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && set_i == '0) |=> ((status_q & ~$past(clr_mask)) == ($past(status_q) & ~$past(clr_mask))));
endmodule

// File: rtl/dma_csr_ptr.sv
module dma_csr_ptr #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_wr,
  input  logic [DATA_W-1:0] base_val,
  input  logic              eng_load,
  input  logic [DATA_W-1:0] eng_val,
  output logic [DATA_W-1:0] base_q,
  output logic [DATA_W-1:0] cur_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
    end else begin
      if (base_wr) base_q <= base_val;
      if (base_wr)       cur_q <= base_val;
      else if (eng_load) cur_q <= eng_val;
    end
  end

  p_base_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (cur_q == $past(base_val) && base_q == $past(base_val)));

  p_eng_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!base_wr && eng_load) |=> (cur_q == $past(eng_val) && $stable(base_q)));
endmodule

// File: rtl/dma_csr_block.sv
module dma_csr_block
  import dma_csr_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 4,
  parameter int unsigned       DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = 32'h0000_1012
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] stat_set,
  input  logic              tx_cur_load,
  input  logic [DATA_W-1:0] tx_cur_value,
  input  logic              rx_cur_load,
  input  logic [DATA_W-1:0] rx_cur_value,
  output logic [DATA_W-1:0] tx_cur_ptr,
  output logic [DATA_W-1:0] rx_cur_ptr,
  output logic [DATA_W-1:0] tx_base,
  output logic [DATA_W-1:0] rx_base,
  output logic [DATA_W-1:0] bus_mode,
  output logic              tx_enable,
  output logic              rx_enable,
  output logic              tx_poll,
  output logic              irq
);
  localparam int unsigned NCH = 2;  // channel 0 = transmit, 1 = receive

  csr_wsel_t         wsel;
  logic [DATA_W-1:0] busmode_q, ctrl_q, ien_q, status_q;
  logic              poll_q;
  logic              rd_req;
  logic [DATA_W-1:0] rd_mux;

  logic [NCH-1:0]             ch_base_wr, ch_load;
  logic [NCH-1:0][DATA_W-1:0] ch_load_val, ch_base, ch_cur;

  dma_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .wsel    (wsel)
  );

  dma_csr_status #(.DATA_W(DATA_W)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_wr  (wsel.status),
    .clr_mask(bus_wdata),
    .set_i   (stat_set),
    .ien     (ien_q),
    .status_q(status_q),
    .irq     (irq)
  );

  assign ch_base_wr  = {wsel.rxbase, wsel.txbase};
  assign ch_load     = {rx_cur_load, tx_cur_load};
  assign ch_load_val = {rx_cur_value, tx_cur_value};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_csr_ptr #(.DATA_W(DATA_W)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_wr (ch_base_wr[g]),
      .base_val(bus_wdata),
      .eng_load(ch_load[g]),
      .eng_val (ch_load_val[g]),
      .base_q  (ch_base[g]),
      .cur_q   (ch_cur[g])
    );
  end

  assign tx_base    = ch_base[0];
  assign rx_base    = ch_base[1];
  assign tx_cur_ptr = ch_cur[0];
  assign rx_cur_ptr = ch_cur[1];

  // Plain configuration registers and the poll strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busmode_q <= '0;
      ctrl_q    <= '0;
      ien_q     <= '0;
      poll_q    <= 1'b0;
    end else begin
      if (wsel.busmode) busmode_q <= {bus_wdata[DATA_W-1:1], 1'b0};
      if (wsel.ctrl)    ctrl_q    <= bus_wdata;
      if (wsel.ien)     ien_q     <= bus_wdata;
      poll_q <= wsel.txpoll;
    end
  end

  assign bus_mode  = busmode_q;
  assign tx_enable = ctrl_q[CTRL_TX_EN_BIT];
  assign rx_enable = ctrl_q[CTRL_RX_EN_BIT];
  assign tx_poll   = poll_q;

  // Read path: one registered stage
  assign rd_req = bus_en && !bus_we;

  always_comb begin
    rd_mux = '0;
    if      (bus_addr == ADDR_W'(ADR_BUSMODE)) rd_mux = busmode_q;
    else if (bus_addr == ADDR_W'(ADR_RXBASE))  rd_mux = ch_base[1];
    else if (bus_addr == ADDR_W'(ADR_TXBASE))  rd_mux = ch_base[0];
    else if (bus_addr == ADDR_W'(ADR_STATUS))  rd_mux = status_q;
    else if (bus_addr == ADDR_W'(ADR_CTRL))    rd_mux = ctrl_q;
    else if (bus_addr == ADDR_W'(ADR_IEN))     rd_mux = ien_q;
    else if (bus_addr == ADDR_W'(ADR_VERSION)) rd_mux = VERSION;
    else if (bus_addr == ADDR_W'(ADR_TXCUR))   rd_mux = ch_cur[0];
    else if (bus_addr == ADDR_W'(ADR_RXCUR))   rd_mux = ch_cur[1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_req;
      bus_rdata  <= rd_req ? rd_mux : '0;
    end
  end

  p_poll_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_poll |-> $past(bus_en && bus_we && bus_addr == ADDR_W'(ADR_TXPOLL)));

  p_version_const_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ADDR_W'(ADR_VERSION)) |=> (bus_rvalid && bus_rdata == VERSION));

  p_busmode_bit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == ADDR_W'(ADR_BUSMODE)) |=> (bus_mode[0] == 1'b0));

  p_irq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0 && status_q != '0));

  p_rvalid_follows_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_en && !bus_we));
endmodule

// File: tb/tb_dma_csr_block.sv
module tb_dma_csr_block;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic [31:0] stat_set = '0;
  logic        tx_cur_load = 1'b0, rx_cur_load = 1'b0;
  logic [31:0] tx_cur_value = '0, rx_cur_value = '0;
  logic [31:0] tx_cur_ptr, rx_cur_ptr, tx_base, rx_base, bus_mode;
  logic        tx_enable, rx_enable, tx_poll, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_block dut (
    .clk(clk), .rst_n(rst_n),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
    .stat_set(stat_set),
    .tx_cur_load(tx_cur_load), .tx_cur_value(tx_cur_value),
    .rx_cur_load(rx_cur_load), .rx_cur_value(rx_cur_value),
    .tx_cur_ptr(tx_cur_ptr), .rx_cur_ptr(rx_cur_ptr),
    .tx_base(tx_base), .rx_base(rx_base), .bus_mode(bus_mode),
    .tx_enable(tx_enable), .rx_enable(rx_enable), .tx_poll(tx_poll), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // Drive at the falling edge, the rising edge acts, release at the next falling edge
  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    check("R10 rvalid on read", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
  endtask

  task automatic pulse_set(input logic [31:0] m);
    @(negedge clk);
    stat_set = m;
    @(negedge clk);
    stat_set = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 16; a++) begin
      bus_read(4'(a), v);
      check(a == 7 ? "R8 version after reset" : "R1 reset value", v, a == 7 ? 32'h1012 : 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx_poll", {31'b0, tx_poll}, 0);
    check("R1 enables", {30'b0, tx_enable, rx_enable}, 0);
    check("R1 pointers", tx_cur_ptr | rx_cur_ptr, 0);
  endtask

  task automatic t_busmode_r6();
    logic [31:0] v;
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_read(4'd0, v);
    check("R6 bus mode read", v, 32'hFFFF_FFFE);
    check("R6 bus mode port", bus_mode, 32'hFFFF_FFFE);
    bus_write(4'd0, 32'h0000_0081);
    check("R6 bus mode port odd", bus_mode, 32'h0000_0080);
  endtask

  task automatic t_ctrl_r9();
    bus_write(4'd5, 32'h0000_2002);
    check("R9 both enables", {30'b0, tx_enable, rx_enable}, 32'h3);
    bus_write(4'd5, 32'h0000_0002);
    check("R9 rx only", {30'b0, tx_enable, rx_enable}, 32'h1);
    bus_write(4'd5, 32'h0000_2000);
    check("R9 tx only", {30'b0, tx_enable, rx_enable}, 32'h2);
  endtask

  task automatic t_version_r8();
    logic [31:0] v;
    bus_write(4'd7, 32'hDEAD_BEEF);
    bus_read(4'd7, v);
    check("R8 version after write", v, 32'h1012);
  endtask

  task automatic t_unmapped_r10();
    logic [31:0] v;
    for (int a = 10; a < 16; a++) begin
      bus_write(4'(a), 32'h1234_5678);
      bus_read(4'(a), v);
      check("R10 unmapped reads zero", v, 0);
    end
    @(negedge clk);
    check("R10 rvalid idle", {31'b0, bus_rvalid}, 0);
  endtask

  task automatic t_poll_r7();
    logic [31:0] v;
    check("R7 poll idle", {31'b0, tx_poll}, 0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
    check("R7 poll strobe", {31'b0, tx_poll}, 1);
    @(negedge clk);
    check("R7 poll one cycle", {31'b0, tx_poll}, 0);
    bus_read(4'd1, v);
    check("R7 poll stores nothing", v, 0);
  endtask

  task automatic t_ptr_r5();
    logic [31:0] v;
    bus_write(4'd2, 32'h0000_1000);
    check("R5 rx base port", rx_base, 32'h0000_1000);
    check("R5 rx cur reload", rx_cur_ptr, 32'h0000_1000);
    bus_read(4'd9, v);
    check("R5 rx cur read", v, 32'h0000_1000);
    @(negedge clk); rx_cur_load = 1'b1; rx_cur_value = 32'h0000_1020;
    @(negedge clk); rx_cur_load = 1'b0;
    check("R5 rx engine load", rx_cur_ptr, 32'h0000_1020);
    check("R5 rx base kept", rx_base, 32'h0000_1000);
    bus_write(4'd9, 32'hAAAA_0000);
    check("R5 rx cur bus write ignored", rx_cur_ptr, 32'h0000_1020);
    bus_write(4'd3, 32'h0000_2000);
    check("R5 tx cur reload", tx_cur_ptr, 32'h0000_2000);
    check("R5 rx untouched by tx base", rx_cur_ptr, 32'h0000_1020);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h0000_3000;
    tx_cur_load = 1'b1; tx_cur_value = 32'h0000_2040;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; tx_cur_load = 1'b0;
    check("R5 base wins over load", tx_cur_ptr, 32'h0000_3000);
    bus_read(4'd3, v);
    check("R5 tx base read", v, 32'h0000_3000);
    bus_write(4'd8, 32'h5555_0000);
    bus_read(4'd8, v);
    check("R5 tx cur bus write ignored", v, 32'h0000_3000);
  endtask

  task automatic t_status_r2_r3_r4();
    logic [31:0] v;
    bus_write(4'd6, 32'h0);
    pulse_set(32'h0000_0041);
    bus_read(4'd4, v);
    check("R3 set TI and RI", v, 32'h0000_0041);
    check("R4 irq masked", {31'b0, irq}, 0);
    bus_write(4'd6, 32'h0000_0040);
    check("R4 irq on enabled bit", {31'b0, irq}, 1);
    bus_write(4'd4, 32'h0000_0000);
    bus_read(4'd4, v);
    check("R2 zero write keeps", v, 32'h0000_0041);
    bus_write(4'd4, 32'h0000_0040);
    bus_read(4'd4, v);
    check("R2 w1c clears RI only", v, 32'h0000_0001);
    check("R4 irq drops", {31'b0, irq}, 0);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h0000_0081;
    stat_set = 32'h0000_0080;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; stat_set = '0;
    bus_read(4'd4, v);
    check("R3 set wins over clear", v, 32'h0000_0080);
    pulse_set(32'h0001_8004);
    bus_read(4'd4, v);
    check("R3 TU AIS NIS bits", v, 32'h0001_8084);
    bus_write(4'd6, 32'h0001_0000);
    check("R4 irq NIS enabled", {31'b0, irq}, 1);
    bus_write(4'd4, 32'hFFFF_FFFF);
    bus_read(4'd4, v);
    check("R2 clear all", v, 0);
    check("R4 irq low after clear", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_busmode_r6();
    t_ctrl_r9();
    t_version_r8();
    t_unmapped_r10();
    t_poll_r7();
    t_ptr_r5();
    t_status_r2_r3_r4();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule